// File: doc/BRIEF.md
# Serial Flash Status and Protection Register

This block holds the eight-bit status word of a serial flash memory: an operation-in-progress flag, the write-enable latch, four block-protect bits, an auto-increment programming flag and a protect-lock bit. It sits behind the command decoder. The decoder sends it one-cycle strobes for each finished command: write enable, write disable, arm-status-write, status write with its data byte, start of an internal program or erase operation, and any other command. The array sequencer sends it strobes for operation completion and for the end of auto-increment programming. The block also samples the write-protect pin, which is active low.

Status writes are guarded in two ways. First, a status write must come directly after an arming command, which is either an arm-status-write or a write enable. Second, a lock bit can freeze the protect field while the write-protect pin is held low. The block offers the register value for status reads. It also drives a write-permission output and a combinational erase-all permission flag for the sequencer.

Top module: `flash_status_reg`

## Requirements
- R1: After reset the status word is 0x1C. Bit 0 is busy, bit 1 is the write-enable latch, bits 5:2 are the protect field, bit 6 is the auto-increment flag and bit 7 is the lock. So after reset the protect bits at positions 2, 3 and 4 are set and all other bits are clear.
- R2: A write enable sets bit 1 in the next cycle. A write disable clears bits 1 and 6 in the next cycle.
- R3: A status write changes bits 5:2 and 7 only when the command just before it was an arm-status-write or a write enable. Any other command in between cancels the arming. Idle cycles do not cancel it.
- R4: A status write that takes effect copies data bits 5:2 and 7 into the register. It leaves bits 0 and 6 as they were. Every status write, whether it takes effect or not, clears bit 1.
- R5: While the write-protect pin is low and bit 7 is 1, a status write leaves bits 5:2 and 7 unchanged.
- R6: While the write-protect pin is low and bit 7 is 0, a status write may set bit 7. While the pin is high, a status write may clear bit 7.
- R7: An operation start is accepted only when bit 1 is 1 and bit 0 is 0. An accepted start sets bit 0. With an operation kind of 1 (auto-increment word), it also sets bit 6. Kind 0 is a single-byte program and kind 2 is an erase. A rejected start changes nothing.
- R8: Operation completion clears bit 0. After a kind 0 operation it also clears bit 1. After kind 1 or kind 2 it keeps bits 1 and 6.
- R9: The end-of-auto-increment strobe clears bits 1 and 6.
- R10: A write disable that arrives during an operation leaves bit 0 set.
- R11: The erase-all permission output is 1 exactly when bits 5:2 are all 0.
- R12: The write-permission output is 1 exactly when bit 1 is 1 and bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wpN | input | 1 | Write-protect pin, active low |
| cmdWren | input | 1 | Write-enable command strobe |
| cmdWrdi | input | 1 | Write-disable command strobe |
| cmdArm | input | 1 | Arm-status-write command strobe |
| cmdStatusWrite | input | 1 | Status-write strobe, given when chip enable rises |
| statusWrData | input | 8 | Data byte of the status write |
| cmdOpStart | input | 1 | Request to start an internal program or erase |
| opKind | input | 2 | Operation kind: 0 byte program, 1 auto-increment word, 2 erase |
| cmdOther | input | 1 | Strobe for any other completed command |
| opDone | input | 1 | Internal operation finished |
| autoEnd | input | 1 | Auto-increment programming ended |
| statusOut | output | 8 | Current status word |
| writeAllowed | output | 1 | Write enabled and not busy |
| eraseAllAllowed | output | 1 | All protect bits clear |

## Verification
A wrong internal state shows up at the ports one cycle after the strobe that caused it, because every register bit drives statusOut directly. A stale arming flag is the exception: it stays hidden until the next status write. For that reason the stimulus puts other commands and lock changes between arming and writing, and then reads the word back. Kind tracking is also invisible until a completion, so each kind is started and completed, and both write-enable and auto flags are compared afterwards.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  localparam int STATUS_W = 8;
  localparam int BP_W = 4;
  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL = 1;
  localparam int BIT_BP_LO = 2;
  localparam int BIT_BP_HI = BIT_BP_LO + BP_W - 1;
  localparam int BIT_AUTO = 6;
  localparam int BIT_LOCK = 7;
  localparam int KIND_W = 2;

  // protect bits 2..4 set after reset
  localparam logic [STATUS_W-1:0] RESET_VALUE = 8'h1C;
  // bits a status write may change: protect field and lock
  localparam logic [STATUS_W-1:0] WRITABLE_MASK = 8'hBC;

  typedef enum logic [KIND_W-1:0] {
    OP_BYTE  = 2'd0,
    OP_AUTO  = 2'd1,
    OP_ERASE = 2'd2
  } opKind_t;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setBusy;
    logic clrBusy;
    logic setAuto;
    logic clrAuto;
    logic writeStatus;
    logic [STATUS_W-1:0] wrData;
  } statusStrobes_t;
endpackage

// File: rtl/fsr_control.sv
module fsr_control
  import flash_status_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cmdWren,
  input  logic cmdWrdi,
  input  logic cmdArm,
  input  logic cmdStatusWrite,
  input  logic [STATUS_W-1:0] statusWrData,
  input  logic cmdOpStart,
  input  logic [KIND_W-1:0] opKind,
  input  logic cmdOther,
  input  logic opDone,
  input  logic autoEnd,
  input  logic welQ,
  input  logic busyQ,
  output statusStrobes_t strb
);
  logic armedQ;
  opKind_t kindQ;
  logic anyCmd;
  logic startOk;

  assign anyCmd = cmdWren | cmdWrdi | cmdArm | cmdStatusWrite | cmdOpStart | cmdOther;
  assign startOk = cmdOpStart && welQ && !busyQ;

  always_comb begin
    strb = '0;
    strb.wrData = statusWrData;
    strb.setWel = cmdWren;
    strb.clrWel = cmdWrdi | cmdStatusWrite | autoEnd | (opDone && busyQ && kindQ == OP_BYTE);
    strb.setBusy = startOk;
    strb.clrBusy = opDone;
    strb.setAuto = startOk && (opKind_t'(opKind) == OP_AUTO);
    strb.clrAuto = cmdWrdi | autoEnd;
    strb.writeStatus = cmdStatusWrite && armedQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      kindQ <= OP_BYTE;
    end else begin
      if (anyCmd) armedQ <= cmdWren | cmdArm;
      if (startOk) kindQ <= opKind_t'(opKind);
    end
  end

  // an unrelated command disarms the status write
  assert_arm_cancel_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOther && !cmdWren && !cmdArm) |=> !armedQ);
endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import flash_status_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wpN,
  input  statusStrobes_t strb,
  output logic welQ,
  output logic busyQ,
  output logic [STATUS_W-1:0] statusQ,
  output logic writeAllowed,
  output logic eraseAllAllowed
);
  logic [STATUS_W-1:0] nextQ;
  logic lockActive;

  assign lockActive = !wpN && statusQ[BIT_LOCK];

  always_comb begin
    nextQ = statusQ;
    if (strb.writeStatus && !lockActive)
      nextQ = (statusQ & ~WRITABLE_MASK) | (strb.wrData & WRITABLE_MASK);
    if (strb.clrBusy) nextQ[BIT_BUSY] = 1'b0;
    else if (strb.setBusy) nextQ[BIT_BUSY] = 1'b1;
    if (strb.clrWel) nextQ[BIT_WEL] = 1'b0;
    else if (strb.setWel) nextQ[BIT_WEL] = 1'b1;
    if (strb.clrAuto) nextQ[BIT_AUTO] = 1'b0;
    else if (strb.setAuto) nextQ[BIT_AUTO] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= RESET_VALUE;
    else statusQ <= nextQ;
  end

  assign welQ = statusQ[BIT_WEL];
  assign busyQ = statusQ[BIT_BUSY];
  assign writeAllowed = welQ && !busyQ;
  assign eraseAllAllowed = (statusQ[BIT_BP_HI:BIT_BP_LO] == '0);

  assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeStatus && !wpN && statusQ[BIT_LOCK]) |=>
      ($stable(statusQ[BIT_BP_HI:BIT_BP_LO]) && statusQ[BIT_LOCK]));

  assert_busy_needs_wel_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(welQ));
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_status_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wpN,
  input  logic cmdWren,
  input  logic cmdWrdi,
  input  logic cmdArm,
  input  logic cmdStatusWrite,
  input  logic [7:0] statusWrData,
  input  logic cmdOpStart,
  input  logic [1:0] opKind,
  input  logic cmdOther,
  input  logic opDone,
  input  logic autoEnd,
  output logic [7:0] statusOut,
  output logic writeAllowed,
  output logic eraseAllAllowed
);
  statusStrobes_t strb;
  logic welQ;
  logic busyQ;

  fsr_control u_control (
    .clk(clk), .rstN(rstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdArm(cmdArm),
    .cmdStatusWrite(cmdStatusWrite), .statusWrData(statusWrData),
    .cmdOpStart(cmdOpStart), .opKind(opKind), .cmdOther(cmdOther),
    .opDone(opDone), .autoEnd(autoEnd),
    .welQ(welQ), .busyQ(busyQ), .strb(strb)
  );

  fsr_datapath u_datapath (
    .clk(clk), .rstN(rstN), .wpN(wpN), .strb(strb),
    .welQ(welQ), .busyQ(busyQ), .statusQ(statusOut),
    .writeAllowed(writeAllowed), .eraseAllAllowed(eraseAllAllowed)
  );

  assert_wel_after_swrite_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStatusWrite && !cmdWren) |=> !statusOut[BIT_WEL]);

  assert_done_clears_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && statusOut[BIT_BUSY]) |=> !statusOut[BIT_BUSY]);

  assert_auto_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (autoEnd && !cmdWren) |=> (!statusOut[BIT_WEL] && !statusOut[BIT_AUTO]));

  assert_wrdi_keeps_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrdi && statusOut[BIT_BUSY] && !opDone) |=> statusOut[BIT_BUSY]);
endmodule

// File: tb/flash_status_reg_bench.sv
module flash_status_reg_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wpN = 1'b1;
  logic cmdWren = 0, cmdWrdi = 0, cmdArm = 0, cmdStatusWrite = 0;
  logic [7:0] statusWrData = 8'h00;
  logic cmdOpStart = 0;
  logic [1:0] opKind = 2'd0;
  logic cmdOther = 0, opDone = 0, autoEnd = 0;
  logic [7:0] statusOut;
  logic writeAllowed, eraseAllAllowed;

  always #2 clk = ~clk;

  flash_status_reg u_flash_status_reg (
    .clk(clk), .rstN(rstN), .wpN(wpN), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi),
    .cmdArm(cmdArm), .cmdStatusWrite(cmdStatusWrite), .statusWrData(statusWrData),
    .cmdOpStart(cmdOpStart), .opKind(opKind), .cmdOther(cmdOther),
    .opDone(opDone), .autoEnd(autoEnd), .statusOut(statusOut),
    .writeAllowed(writeAllowed), .eraseAllAllowed(eraseAllAllowed)
  );

  typedef struct packed {
    bit wren; bit wrdi; bit arm; bit sw; bit [7:0] data;
    bit start; bit [1:0] kind; bit done; bit aend; bit other;
  } stim_t;

  typedef struct {
    logic [7:0] status; logic wa; logic ea; string tag;
  } expect_t;

  expect_t q[$];
  int checks = 0;
  int fails = 0;

  // reference model state
  bit mArmed = 0, mWel = 0, mBusy = 0, mAuto = 0, mLock = 0;
  bit [3:0] mBp = 4'b0111;
  bit [1:0] mKind = 0;

  function automatic logic [7:0] modelWord();
    return {mLock, mAuto, mBp, mWel, mBusy};
  endfunction

  task automatic apply(input stim_t s, input string tag);
    expect_t e;
    bit anyCmd;
    @(negedge clk);
    cmdWren = s.wren; cmdWrdi = s.wrdi; cmdArm = s.arm; cmdStatusWrite = s.sw;
    statusWrData = s.data; cmdOpStart = s.start; opKind = s.kind;
    opDone = s.done; autoEnd = s.aend; cmdOther = s.other;
    @(posedge clk);
    #1;
    anyCmd = s.wren | s.wrdi | s.arm | s.sw | s.start | s.other;
    if (s.sw) begin
      if (mArmed && !(!wpN && mLock)) begin
        mBp = s.data[5:2];
        mLock = s.data[7];
      end
      mWel = 0;
    end
    if (s.wren) mWel = 1;
    if (s.wrdi) begin mWel = 0; mAuto = 0; end
    if (s.start && mWel && !mBusy) begin
      mBusy = 1; mKind = s.kind;
      if (s.kind == 2'd1) mAuto = 1;
    end
    if (s.done && mBusy) begin
      mBusy = 0;
      if (mKind == 2'd0) mWel = 0;
    end
    if (s.aend) begin mWel = 0; mAuto = 0; end
    if (anyCmd) mArmed = s.wren | s.arm;
    e.status = modelWord();
    e.wa = mWel && !mBusy;
    e.ea = (mBp == 4'b0000);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    cmdWren = 0; cmdWrdi = 0; cmdArm = 0; cmdStatusWrite = 0; statusWrData = 0;
    cmdOpStart = 0; opKind = 0; opDone = 0; autoEnd = 0; cmdOther = 0;
  endtask

  task automatic doWren(input string t); stim_t s = '0; s.wren = 1; apply(s, t); endtask
  task automatic doWrdi(input string t); stim_t s = '0; s.wrdi = 1; apply(s, t); endtask
  task automatic doArm(input string t); stim_t s = '0; s.arm = 1; apply(s, t); endtask
  task automatic doOther(input string t); stim_t s = '0; s.other = 1; apply(s, t); endtask
  task automatic doIdle(input string t); stim_t s = '0; apply(s, t); endtask
  task automatic doDone(input string t); stim_t s = '0; s.done = 1; apply(s, t); endtask
  task automatic doAutoEnd(input string t); stim_t s = '0; s.aend = 1; apply(s, t); endtask
  task automatic doWrite(input logic [7:0] d, input string t);
    stim_t s = '0; s.sw = 1; s.data = d; apply(s, t);
  endtask
  task automatic doStart(input logic [1:0] k, input string t);
    stim_t s = '0; s.start = 1; s.kind = k; apply(s, t);
  endtask

  // monitor: compare each expected item against the ports
  always @(negedge clk) begin
    if (q.size() > 0) begin
      expect_t e;
      e = q.pop_front();
      checks++;
      if (statusOut !== e.status || writeAllowed !== e.wa || eraseAllAllowed !== e.ea) begin
        fails++;
        $display("FAIL %s: status=%h wa=%b ea=%b expected status=%h wa=%b ea=%b",
                 e.tag, statusOut, writeAllowed, eraseAllAllowed, e.status, e.wa, e.ea);
      end
    end
  end

  int cycles = 0;
  bit finished = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    doIdle("R1 reset word and outputs");
    doWrite(8'h00, "R3 unarmed write ignored");
    doArm("R3 arm");
    doWrite(8'h00, "R3 armed write clears protect, R11 erase-all allowed");
    doWren("R2 write enable, R12 write allowed");
    doOther("R3 other command");
    doWrite(8'hBC, "R3 arming cancelled by other command");
    doWren("R3 arm by write enable");
    doIdle("R3 idle keeps arming");
    doWrite(8'hFF, "R4 masked write and latch cleared");
    wpN = 0;
    doArm("R5 arm with lock");
    doWrite(8'h00, "R5 locked write ignored");
    wpN = 1;
    doArm("R6 arm pin high");
    doWrite(8'h00, "R6 lock cleared with pin high");
    wpN = 0;
    doArm("R6 arm pin low");
    doWrite(8'h80, "R6 lock set with pin low");
    wpN = 1;
    doArm("R6 arm");
    doWrite(8'h00, "R6 unlock");
    doStart(2'd0, "R7 start rejected without latch");
    doWren("R7 enable");
    doStart(2'd0, "R7 byte program accepted, R12 not allowed while busy");
    doStart(2'd2, "R7 start while busy ignored");
    doWrdi("R10 write disable keeps busy");
    doDone("R8 completion clears busy");
    doWren("R8 enable");
    doStart(2'd0, "R7 byte program");
    doDone("R8 byte completion clears latch");
    doWren("R8 enable");
    doStart(2'd2, "R7 erase start");
    doDone("R8 erase completion keeps latch");
    doStart(2'd1, "R7 auto word start sets auto flag");
    doDone("R8 auto completion keeps latch and flag");
    doStart(2'd1, "R7 next auto word");
    doDone("R8 auto completion");
    doAutoEnd("R9 auto end clears latch and flag");
    doWren("R2 enable");
    doStart(2'd1, "R7 auto start");
    doDone("R8 auto done");
    doWrdi("R2 write disable clears latch and auto flag");
    doWren("R4 arm by enable");
    doWrite(8'h20, "R4 write protect top bit, R11 not allowed");
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule